// File: doc/BRIEF.md
# JTAG Host Scan Sequencer

This block is a JTAG master inside a chip. It drives TCK, TMS and TDI and samples TDO so that on-chip logic can run scans on an attached test access port. A client pulses `start_i` with one of two requests. The first selects one of two user scan chains by loading the instruction register. The second shifts a data register of a given length. When the sequence is complete, the captured TDO bits are on `rx_o` and `done_o` pulses for one cycle.

Every instruction load begins with a forced trip through Test-Logic-Reset. Each scan starts and ends in Run-Test/Idle. TCK comes from the system clock divided by an even ratio, and the client never handles the TMS walking sequences itself. A request that carries an unknown chain index or a bad length is refused with an error pulse, and no TCK edge follows it.

Top module: `jtag_scan_seq`

## Requirements
- R1: A chain-select request (`kind_i`=0) first drives TMS high for six TCK cycles, which puts the TAP in Test-Logic-Reset, and then low for one cycle to reach Run-Test/Idle. The whole instruction load takes 19 TCK cycles.
- R2: From Run-Test/Idle the instruction load walks TMS 1,1,0,0 into Shift-IR and shifts a 6-bit opcode. Chain 1 loads 0x02 and chain 2 loads 0x03.
- R3: A data-scan request (`kind_i`=1) walks TMS 1,0,0 from Run-Test/Idle into Shift-DR. A scan of N bits takes N+5 TCK cycles in total.
- R4: Bits are shifted least-significant first, with TDI taken from `tx_i[k]` on shift cycle k. TMS stays low for the first N-1 bits and goes high with the final bit.
- R5: After the final bit, TMS goes 1 and then 0, passing through Update into Run-Test/Idle. The TAP is in Run-Test/Idle when `done_o` pulses.
- R6: A chain-select request with `chain_i` other than 1 or 2 pulses `err_o` for one cycle in the cycle after `start_i`. It produces no TCK edge and `busy_o` stays low.
- R7: A data-scan request with length 0, or with a length above MAX_DR, is refused in the same way as R6.
- R8: The TDO bit sampled on the rising TCK edge of shift cycle k, including the final Exit1 cycle, is stored in `rx_o[k]`. All other bits of `rx_o` are cleared when a request is accepted. On an instruction load, `rx_o` holds the bits captured from the instruction register.
- R9: Data scans of 1 up to MAX_DR (default 64) bits are supported, which includes a 42-bit frame in a single scan.
- R10: TCK runs at the system clock divided by CLK_DIV with a 50% duty cycle and is low while idle. TMS and TDI change only when TCK falls, and TDO is sampled when TCK rises.
- R11: `start_i` is acted on only while `busy_o` is low. `busy_o` stays high for the whole sequence. `done_o` is a one-cycle pulse in the first cycle after `busy_o` falls.
- R12: The synchronous active-low reset `rst_n` returns the block to idle with TCK low, TMS high, `rx_o` cleared, and `busy_o`, `done_o` and `err_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request pulse |
| kind_i | input | 1 | 0 = chain select (instruction load), 1 = data scan |
| chain_i | input | 2 | Chain index for a chain select (1 or 2) |
| len_i | input | LW (7) | Data-scan length in bits |
| tx_i | input | MAX_DR (64) | Transmit vector, bit 0 shifted first |
| rx_o | output | MAX_DR (64) | Captured receive vector |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle rejection pulse |
| tck_o | output | 1 | Test clock |
| tms_o | output | 1 | Test mode select |
| tdi_o | output | 1 | Test data to the TAP |
| tdo_i | input | 1 | Test data from the TAP |

## Verification
The assertions assume that the client samples `rx_o` only after `done_o`. They also assume that `tdo_i` is a signal external to the block, so that no check depends on its value.

They further assume that a data scan is issued only after a chain select has left the TAP in Run-Test/Idle, because the sequencer does not reset the TAP before a data scan.

The stimulus follows both rules. It opens with a chain select and repeats one after the mid-scan reset. It drives `start_i` at falling system-clock edges. It uses a behavioural TAP model whose TDO follows its shift registers, so the captured vectors and the values latched at Update can be predicted from the capture patterns and from `tx_i`.

// File: rtl/jtag_seq_pkg.sv
// Package: shared types and constants of the JTAG host scan sequencer.
// Assumes: a TAP with the standard 16-state controller.
package jtag_seq_pkg;

    // Segments of a scan; each segment is a run of TCK cycles with a TMS rule.
    typedef enum logic [2:0] {
        SEG_IDLE   = 3'd0,
        SEG_RESET  = 3'd1,
        SEG_SETTLE = 3'd2,
        SEG_TO_IR  = 3'd3,
        SEG_TO_DR  = 3'd4,
        SEG_SHIFT  = 3'd5,
        SEG_EXIT   = 3'd6
    } seg_e;

    localparam int RESET_CYCLES = 6;   // TMS-high cycles to force Test-Logic-Reset
    localparam int TO_IR_CYCLES = 4;   // 1,1,0,0
    localparam int TO_DR_CYCLES = 3;   // 1,0,0
    localparam int EXIT_CYCLES  = 2;   // 1,0

endpackage

// File: rtl/jtag_tck_gen.sv
// Module: jtag_tck_gen
// Makes TCK from the system clock divided by DIV (even, >= 2) while run_i is high.
// It flags in the same cycle the system-clock edges at which TCK rises or falls.
// Assumes: run_i drops only in the cycle after a falling event, so TCK stops low.
module jtag_tck_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tck_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int HALF = DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] ph_q;
    logic          tck_q;
    logic          edge_w;

    assign edge_w = run_i && (ph_q == CW'(HALF - 1));
    assign rise_o = edge_w && !tck_q;
    assign fall_o = edge_w && tck_q;
    assign tck_o  = tck_q;

    // Half-period counter and TCK toggle flop.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            ph_q  <= '0;
            tck_q <= 1'b0;
        end else if (edge_w) begin
            ph_q  <= '0;
            tck_q <= ~tck_q;
        end else begin
            ph_q  <= ph_q + CW'(1);
        end
    end

    // R10: once the run request is gone, TCK is low.
    p_stop_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !tck_o);

endmodule

// File: rtl/jtag_scan_shifter.sv
// Module: jtag_scan_shifter
// Holds the transmit vector and collects the receive vector, one bit per shift cycle.
// Bits are addressed by idx_i rather than shifted, so no register moves per TCK.
// Assumes: idx_i < W whenever sh_i or cap_i is high.
module jtag_scan_shifter #(
    parameter int W  = 64,
    parameter int IW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [W-1:0]  vec_i,
    input  logic          sh_i,
    input  logic          cap_i,
    input  logic [IW-1:0] idx_i,
    input  logic          tdo_i,
    output logic          tdi_o,
    output logic [W-1:0]  rx_o
);
    logic [W-1:0] tx_q;
    logic [W-1:0] rx_q;

    assign tdi_o = sh_i ? tx_q[idx_i] : 1'b0;
    assign rx_o  = rx_q;

    // Load the outgoing vector and clear the incoming one on request accept; capture TDO.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
            rx_q <= '0;
        end else if (load_i) begin
            tx_q <= vec_i;
            rx_q <= '0;
        end else if (cap_i) begin
            rx_q[idx_i] <= tdo_i;
        end
    end

    // R8: an accepted request leaves the receive vector empty in the next cycle.
    p_rx_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (rx_o == '0));

endmodule

// File: rtl/jtag_scan_ctrl.sv
// Module: jtag_scan_ctrl
// Checks requests, then walks the segment sequence one TCK cycle at a time.
// It advances on falling TCK events and produces TMS, the shift index and the strobes.
// Assumes: fall_i/rise_i come from a TCK generator that runs only while busy_o is high.
module jtag_scan_ctrl
    import jtag_seq_pkg::*;
#(
    parameter int IR_BITS = 6,
    parameter int MAX_DR  = 64,
    parameter int LW      = 7,
    parameter int IW      = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          kind_i,
    input  logic [1:0]    chain_i,
    input  logic [LW-1:0] len_i,
    input  logic          rise_i,
    input  logic          fall_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          err_o,
    output logic          tms_o,
    output logic          load_o,
    output logic          sh_o,
    output logic          cap_o,
    output logic [IW-1:0] idx_o
);
    seg_e          seg_q;
    seg_e          seg_nxt;
    logic [LW-1:0] cnt_q;
    logic [LW-1:0] last_q;
    logic [LW-1:0] seg_end;
    logic          done_q;
    logic          err_q;
    logic          idle_tms_q;
    logic          req_ok;
    logic          seg_tms;

    // Request check: chain index 1 or 2, or a scan length within 1..MAX_DR.
    always_comb begin
        if (kind_i)
            req_ok = (len_i != '0) && (len_i <= LW'(MAX_DR));
        else
            req_ok = (chain_i == 2'd1) || (chain_i == 2'd2);
    end

    // Length of the current segment (last count value) and its successor.
    always_comb begin
        seg_end = '0;
        seg_nxt = SEG_IDLE;
        unique case (seg_q)
            SEG_RESET:  begin seg_end = LW'(RESET_CYCLES - 1); seg_nxt = SEG_SETTLE; end
            SEG_SETTLE: begin seg_end = '0;                    seg_nxt = SEG_TO_IR;  end
            SEG_TO_IR:  begin seg_end = LW'(TO_IR_CYCLES - 1); seg_nxt = SEG_SHIFT;  end
            SEG_TO_DR:  begin seg_end = LW'(TO_DR_CYCLES - 1); seg_nxt = SEG_SHIFT;  end
            SEG_SHIFT:  begin seg_end = last_q;                seg_nxt = SEG_EXIT;   end
            SEG_EXIT:   begin seg_end = LW'(EXIT_CYCLES - 1);  seg_nxt = SEG_IDLE;   end
            default:    begin seg_end = '0;                    seg_nxt = SEG_IDLE;   end
        endcase
    end

    // TMS value for the current TCK cycle of each segment.
    always_comb begin
        unique case (seg_q)
            SEG_RESET:  seg_tms = 1'b1;
            SEG_SETTLE: seg_tms = 1'b0;
            SEG_TO_IR:  seg_tms = (cnt_q < LW'(2));
            SEG_TO_DR:  seg_tms = (cnt_q == '0);
            SEG_SHIFT:  seg_tms = (cnt_q == last_q);
            SEG_EXIT:   seg_tms = (cnt_q == '0);
            default:    seg_tms = idle_tms_q;
        endcase
    end

    assign busy_o = (seg_q != SEG_IDLE);
    assign done_o = done_q;
    assign err_o  = err_q;
    assign tms_o  = seg_tms;
    assign load_o = (seg_q == SEG_IDLE) && start_i && req_ok;
    assign sh_o   = (seg_q == SEG_SHIFT);
    assign cap_o  = sh_o && rise_i;
    assign idx_o  = cnt_q[IW-1:0];

    // Segment sequencer: accepts in idle, steps one count per falling TCK event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q      <= SEG_IDLE;
            cnt_q      <= '0;
            last_q     <= '0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
            idle_tms_q <= 1'b1;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            if (seg_q == SEG_IDLE) begin
                if (start_i && req_ok) begin
                    seg_q  <= kind_i ? SEG_TO_DR : SEG_RESET;
                    cnt_q  <= '0;
                    last_q <= kind_i ? (len_i - LW'(1)) : LW'(IR_BITS - 1);
                end else if (start_i) begin
                    err_q <= 1'b1;
                end
            end else if (fall_i) begin
                if (cnt_q == seg_end) begin
                    seg_q <= seg_nxt;
                    cnt_q <= '0;
                    if (seg_q == SEG_EXIT) begin
                        done_q     <= 1'b1;
                        idle_tms_q <= 1'b0;
                    end
                end else begin
                    cnt_q <= cnt_q + LW'(1);
                end
            end
        end
    end

    // R11: done is a single-cycle pulse that follows the end of busy.
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_done_after_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));
    // R6: a rejected request never starts a sequence.
    p_err_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !busy_o);

endmodule

// File: rtl/jtag_scan_seq.sv
// Module: jtag_scan_seq (top)
// JTAG master: chain select by instruction load, or a data scan of 1..MAX_DR bits.
// Assumes: the attached TAP is in Run-Test/Idle before a data scan is requested.
module jtag_scan_seq #(
    parameter int CLK_DIV = 4,
    parameter int IR_BITS = 6,
    parameter int MAX_DR  = 64,
    parameter int LW      = $clog2(MAX_DR + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              kind_i,
    input  logic [1:0]        chain_i,
    input  logic [LW-1:0]     len_i,
    input  logic [MAX_DR-1:0] tx_i,
    output logic [MAX_DR-1:0] rx_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic              tck_o,
    output logic              tms_o,
    output logic              tdi_o,
    input  logic              tdo_i
);
    localparam int IW = (MAX_DR > 1) ? $clog2(MAX_DR) : 1;

    logic              rise_w;
    logic              fall_w;
    logic              load_w;
    logic              sh_w;
    logic              cap_w;
    logic [IW-1:0]     idx_w;
    logic [MAX_DR-1:0] vec_w;
    logic [IR_BITS-1:0] opcode_w;

    // Chain index n maps to user opcode n+1 (1 -> 0x02, 2 -> 0x03).
    assign opcode_w = IR_BITS'(chain_i) + IR_BITS'(1);
    assign vec_w    = kind_i ? tx_i : MAX_DR'(opcode_w);

    jtag_scan_ctrl #(
        .IR_BITS (IR_BITS),
        .MAX_DR  (MAX_DR),
        .LW      (LW),
        .IW      (IW)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .kind_i  (kind_i),
        .chain_i (chain_i),
        .len_i   (len_i),
        .rise_i  (rise_w),
        .fall_i  (fall_w),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .err_o   (err_o),
        .tms_o   (tms_o),
        .load_o  (load_w),
        .sh_o    (sh_w),
        .cap_o   (cap_w),
        .idx_o   (idx_w)
    );

    jtag_tck_gen #(
        .DIV (CLK_DIV)
    ) u_tck (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (busy_o),
        .tck_o  (tck_o),
        .rise_o (rise_w),
        .fall_o (fall_w)
    );

    jtag_scan_shifter #(
        .W  (MAX_DR),
        .IW (IW)
    ) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_w),
        .vec_i  (vec_w),
        .sh_i   (sh_w),
        .cap_i  (cap_w),
        .idx_i  (idx_w),
        .tdo_i  (tdo_i),
        .tdi_o  (tdi_o),
        .rx_o   (rx_o)
    );

    // R10: TMS and TDI hold still while TCK is high.
    p_tms_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tck_o |-> ($stable(tms_o) && $stable(tdi_o)));
    // R10: TCK is low whenever no sequence runs.
    p_tck_idle_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !tck_o);

endmodule

// File: tb/jtag_scan_seq_tb.sv
module jtag_scan_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MAXB = 64;
    localparam logic [63:0] CAP1 = 64'hA5C3_0F96_1E2D_7B48;
    localparam logic [63:0] CAP2 = 64'h0123_4567_89AB_CDEF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, kind_i = 1'b0;
    logic [1:0] chain_i = 2'd0;
    logic [6:0] len_i = 7'd0;
    logic [63:0] tx_i = 64'd0;
    logic [63:0] rx_o;
    logic busy_o, done_o, err_o, tck_o, tms_o, tdi_o, tdo_i;

    int n_chk = 0, n_bad = 0;
    int rises = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    jtag_scan_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .kind_i(kind_i),
        .chain_i(chain_i), .len_i(len_i), .tx_i(tx_i), .rx_o(rx_o),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .tck_o(tck_o),
        .tms_o(tms_o), .tdi_o(tdi_o), .tdo_i(tdo_i)
    );

    // Behavioural TAP model.
    typedef enum logic [3:0] {
        T_TLR, T_RTI, T_SDR, T_CDR, T_SHDR, T_E1DR, T_PDR, T_E2DR, T_UDR,
        T_SIR, T_CIR, T_SHIR, T_E1IR, T_PIR, T_E2IR, T_UIR
    } tap_e;
    tap_e ts = T_TLR;
    logic [5:0] ir = 6'h09, ir_sr = 6'h00;
    logic [63:0] dr = 64'd0, dr_upd = 64'd0;
    logic tlr_seen = 1'b0;

    assign tdo_i = (ts == T_SHIR) ? ir_sr[0] : dr[0];

    always @(posedge tck_o) begin
        rises <= rises + 1;
        case (ts)
            T_TLR:  begin ir <= 6'h09; tlr_seen <= 1'b1; end
            T_CDR:  dr <= (ir == 6'h02) ? CAP1 : ((ir == 6'h03) ? CAP2 : 64'd0);
            T_SHDR: dr <= {tdi_o, dr[63:1]};
            T_UDR:  dr_upd <= dr;
            T_CIR:  ir_sr <= 6'b000001;
            T_SHIR: ir_sr <= {tdi_o, ir_sr[5:1]};
            T_UIR:  ir <= ir_sr;
            default: ;
        endcase
        case (ts)
            T_TLR:  ts <= tms_o ? T_TLR  : T_RTI;
            T_RTI:  ts <= tms_o ? T_SDR  : T_RTI;
            T_SDR:  ts <= tms_o ? T_SIR  : T_CDR;
            T_CDR:  ts <= tms_o ? T_E1DR : T_SHDR;
            T_SHDR: ts <= tms_o ? T_E1DR : T_SHDR;
            T_E1DR: ts <= tms_o ? T_UDR  : T_PDR;
            T_PDR:  ts <= tms_o ? T_E2DR : T_PDR;
            T_E2DR: ts <= tms_o ? T_UDR  : T_SHDR;
            T_UDR:  ts <= tms_o ? T_SDR  : T_RTI;
            T_SIR:  ts <= tms_o ? T_TLR  : T_CIR;
            T_CIR:  ts <= tms_o ? T_E1IR : T_SHIR;
            T_SHIR: ts <= tms_o ? T_E1IR : T_SHIR;
            T_E1IR: ts <= tms_o ? T_UIR  : T_PIR;
            T_PIR:  ts <= tms_o ? T_E2IR : T_PIR;
            T_E2IR: ts <= tms_o ? T_UIR  : T_SHIR;
            default: ts <= tms_o ? T_SDR : T_RTI;
        endcase
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Pulse a request for one cycle at falling edges.
    task automatic issue(input logic k, input logic [1:0] c, input logic [6:0] l, input logic [63:0] t);
        @(negedge clk);
        kind_i = k; chain_i = c; len_i = l; tx_i = t; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done(output bit got);
        got = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            if (done_o) begin got = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    // Stimulus table: {kind, chain, len, tx}.
    localparam int NV = 7;
    localparam logic [73:0] TBL [NV] = '{
        {1'b0, 2'd1, 7'd0,  64'd0},
        {1'b1, 2'd0, 7'd8,  64'h0000_0000_0000_00AB},
        {1'b1, 2'd0, 7'd42, 64'h0000_02AB_CDEF_1234},
        {1'b0, 2'd2, 7'd0,  64'd0},
        {1'b1, 2'd0, 7'd1,  64'h0000_0000_0000_0001},
        {1'b1, 2'd0, 7'd64, 64'hDEAD_BEEF_CAFE_F00D},
        {1'b1, 2'd0, 7'd13, 64'h0000_0000_0000_1A5A}
    };

    // Run one table-style request and compare against the TAP model expectations.
    task automatic run_and_check(input logic k, input logic [1:0] c, input int n, input logic [63:0] t,
                                 input logic [63:0] cap);
        bit got;
        logic [63:0] mask, exp_rx, exp_dr;
        int r0;
        r0 = rises;
        tlr_seen = 1'b0;
        issue(k, c, 7'(n), t);
        check(busy_o == 1'b1, "R11 busy during sequence", 64'(busy_o), 64'd1);
        wait_done(got);
        check(got, "R11 done pulse seen", 64'(got), 64'd1);
        check(ts == T_RTI, "R5 TAP parked in Run-Test/Idle", 64'(ts), 64'(T_RTI));
        check(busy_o == 1'b0 && tck_o == 1'b0, "R10 TCK low and idle at done", {busy_o, tck_o}, 64'd0);
        if (!k) begin
            check(tlr_seen, "R1 Test-Logic-Reset visited", 64'(tlr_seen), 64'd1);
            check(rises - r0 == 19, "R1 instruction load TCK count", 64'(rises - r0), 64'd19);
            check(ir == 6'(c + 1), "R2 opcode for chain", 64'(ir), 64'(c + 1));
            check(rx_o == 64'h1, "R8 IR capture bits", rx_o, 64'h1);
        end else begin
            mask   = (n == 64) ? '1 : ((64'd1 << n) - 64'd1);
            exp_rx = cap & mask;
            exp_dr = (cap >> n) | ((t & mask) << (64 - n));
            check(rises - r0 == n + 5, "R3 data scan TCK count", 64'(rises - r0), 64'(n + 5));
            check(rx_o == exp_rx, "R8 R9 receive vector", rx_o, exp_rx);
            check(dr_upd == exp_dr, "R4 LSB-first shifted data", dr_upd, exp_dr);
        end
        @(negedge clk);
        check(done_o == 1'b0, "R11 done lasts one cycle", 64'(done_o), 64'd0);
    endtask

    task automatic reject(input logic k, input logic [1:0] c, input logic [6:0] l, input string req);
        int r0;
        r0 = rises;
        @(negedge clk);
        kind_i = k; chain_i = c; len_i = l; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(err_o == 1'b1 && busy_o == 1'b0, req, {err_o, busy_o}, 64'h2);
        repeat (12) @(negedge clk);
        check(rises == r0 && err_o == 1'b0, req, 64'(rises - r0), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [63:0] cur_cap;
        bit got;
        int r0;
        cur_cap = 64'd0;
        repeat (4) @(negedge clk);
        // R12 reset state
        check(tck_o == 1'b0, "R12 TCK low in reset", 64'(tck_o), 64'd0);
        check(tms_o == 1'b1, "R12 TMS high in reset", 64'(tms_o), 64'd1);
        check(rx_o == 64'd0, "R12 receive vector cleared", rx_o, 64'd0);
        check({busy_o, done_o, err_o} == 3'b000, "R12 status low", 64'({busy_o, done_o, err_o}), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            if (!TBL[v][73]) cur_cap = (TBL[v][72:71] == 2'd1) ? CAP1 : CAP2;
            run_and_check(TBL[v][73], TBL[v][72:71], int'(TBL[v][70:64]), TBL[v][63:0], cur_cap);
        end

        // R6 / R7 rejections
        reject(1'b0, 2'd0, 7'd0, "R6 chain 0 rejected");
        reject(1'b0, 2'd3, 7'd0, "R6 chain 3 rejected");
        reject(1'b1, 2'd0, 7'd0, "R7 zero length rejected");
        reject(1'b1, 2'd0, 7'd65, "R7 over-length rejected");

        // R11: a start while busy is ignored
        r0 = rises;
        issue(1'b1, 2'd0, 7'd8, 64'h0000_0000_0000_0055);
        repeat (10) @(negedge clk);
        kind_i = 1'b0; chain_i = 2'd1; tx_i = 64'hFFFF; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done(got);
        check(got && rises - r0 == 13, "R11 busy start ignored, count", 64'(rises - r0), 64'd13);
        check(rx_o == (CAP2 & 64'hFF), "R11 busy start ignored, rx", rx_o, CAP2 & 64'hFF);
        repeat (30) @(negedge clk);
        check(rises - r0 == 13 && ir == 6'h03, "R11 no second sequence", 64'(rises - r0), 64'd13);

        // R12: reset in the middle of a scan
        issue(1'b1, 2'd0, 7'd20, 64'h0000_0000_000A_BCDE);
        repeat (15) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(tck_o == 1'b0 && tms_o == 1'b1, "R12 mid-scan reset pins", {tck_o, tms_o}, 64'h1);
        check(rx_o == 64'd0 && busy_o == 1'b0, "R12 mid-scan reset state", rx_o, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run_and_check(1'b0, 2'd1, 0, 64'd0, CAP1);
        run_and_check(1'b1, 2'd0, 42, 64'h0000_0155_AA55_F00F, CAP1);

        finish_run();
    end
endmodule